// File: doc/BRIEF.md
# Programmable Divider and Interval Timer

An 8-bit timer peripheral for a byte-wide register bus. A free-running divider counts system clock ticks, and a second counter counts at one of four selectable rates while enabled. When that counter passes its top value it is reloaded from a modulo register and a one-cycle interrupt request is pulsed. An interrupt controller collects the request, and software sets the interval by choosing the rate and the modulo.

The block advances only on cycles where the `tick` enable is high. It has four byte registers at consecutive addresses from a base address: divider, counter, modulo and control. Read data is registered and returned one cycle after the read strobe, together with a valid flag. The rate-select bits in the control register are latched only by a write that moves the timer from disabled to enabled.

Top module: `timer_periph`

## Requirements
- R1: After a synchronous reset, all four registers read 0x00, the timer is disabled with rate select 00, both prescalers are cleared and `irq` is low.
- R2: The divider register (offset 0) increments once every 256 ticks and wraps from 0xFF to 0x00 with no interrupt or other side effect.
- R3: A write of any data to the divider offset clears the divider and its prescaler, so the next increment comes 256 ticks after the write edge.
- R4: Control bit 2 enables the counter (offset 1). Control bits 1:0 give the counter period in ticks: 00 is 1024, 01 is 16, 10 is 64 and 11 is 256.
- R5: When the counter would increment past 0xFF, it loads the modulo register (offset 2) instead. `irq` is high for exactly one cycle, in the same cycle the reloaded value appears.
- R6: While the enable bit is clear, the counter and its prescaler hold, and the divider keeps counting.
- R7: A control write with bit 2 set while the timer is disabled latches bits 1:0 as the new rate and restarts the counter prescaler from zero. A control write while enabled changes only the enable bit. A disabling write keeps the latched rate.
- R8: Reading control (offset 3) returns the latched rate in bits 1:0, the enable flag in bit 2, and zeros in bits 7:3. Writes to the counter and modulo offsets load those registers, and they read back unchanged.
- R9: A read returns its data and a high `bus_rvalid` on the cycle after the read strobe. A read outside the four addresses returns 0x00 with `bus_rvalid` low.
- R10: A bus write to the counter on the same edge as an overflow wins over the modulo reload, and no interrupt is raised for that overflow.
- R11: While `tick` is low, neither the divider, the counter nor either prescaler advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle advance enable for all counting |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | High when bus_rdata holds an in-range read |
| irq | output | 1 | One-cycle interrupt request on counter overflow |

## Verification
All four rate selections are swept from a start value just below the top. Some modulo values sit inside the range, and one is 0xFF, which forces an overflow on every step. This separates the period decode, the reload value and the interrupt count. Reads are placed at the exact tick boundaries on either side of an increment, so an off-by-one in either prescaler shows up. Separate patterns cover rate-latch ordering (a re-enable with new rate bits, then a write while enabled), a counter write that collides with an overflow, gating by disable and by `tick`, and a full divider wrap.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NUM_REGS   = 4;
  localparam int RATE_W     = 2;
  localparam int NUM_RATES  = 1 << RATE_W;
  localparam int CTL_EN_BIT = 2;

  typedef enum logic [1:0] {
    OFS_DIV = 2'd0,
    OFS_CNT = 2'd1,
    OFS_MOD = 2'd2,
    OFS_CTL = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic              en;
    logic [RATE_W-1:0] rate;
  } ctl_t;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/timer_bus.sv
module timer_bus
  import timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hFF04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] div_val,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic [DATA_W-1:0] mod_val,
  input  ctl_t              ctl_val,
  output logic              div_clr,
  output logic              cnt_wr,
  output logic              mod_wr,
  output logic              ctl_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam logic [ADDR_W:0] ADDR_LO = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] ADDR_HI = ADDR_LO + (ADDR_W+1)'(NUM_REGS);

  logic [ADDR_W:0]   addr_x;
  logic              hit;
  reg_ofs_e          ofs;
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] rd_mux;

  assign addr_x = {1'b0, bus_addr};
  assign hit    = (addr_x >= ADDR_LO) && (addr_x < ADDR_HI);
  assign ofs    = reg_ofs_e'(bus_addr[1:0] - BASE_ADDR[1:0]);

  assign div_clr = bus_wr && hit && (ofs == OFS_DIV);
  assign cnt_wr  = bus_wr && hit && (ofs == OFS_CNT);
  assign mod_wr  = bus_wr && hit && (ofs == OFS_MOD);
  assign ctl_wr  = bus_wr && hit && (ofs == OFS_CTL);

  always_comb begin
    ctl_word                 = '0;
    ctl_word[CTL_EN_BIT]     = ctl_val.en;
    ctl_word[RATE_W-1:0]     = ctl_val.rate;
  end

  always_comb begin
    case (ofs)
      OFS_DIV: rd_mux = div_val;
      OFS_CNT: rd_mux = cnt_val;
      OFS_MOD: rd_mux = mod_val;
      default: rd_mux = ctl_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd && hit;
      bus_rdata  <= (bus_rd && hit) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/timer_divider.sv
module timer_divider #(
  parameter int DATA_W     = 8,
  parameter int DIV_PERIOD = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clr,
  output logic [DATA_W-1:0] div_q
);
  localparam int PW = (DIV_PERIOD > 1) ? $clog2(DIV_PERIOD) : 1;
  localparam logic [PW-1:0] LIM = PW'(DIV_PERIOD - 1);

  logic [PW-1:0] pre_q;
  logic          roll;

  assign roll = tick && (pre_q == LIM);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (tick) begin
      pre_q <= roll ? '0 : pre_q + 1'b1;
      if (roll) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              wr_en_bit,
  input  logic [RATE_W-1:0] wr_rate,
  output ctl_t              ctl_q,
  output logic              restart
);
  assign restart = wr && wr_en_bit && !ctl_q.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr) begin
      ctl_q.en <= wr_en_bit;
      if (restart) ctl_q.rate <= wr_rate;
    end
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PERIOD0 = 1024,
  parameter int PERIOD1 = 16,
  parameter int PERIOD2 = 64,
  parameter int PERIOD3 = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  input  logic              restart,
  input  logic              cnt_wr,
  input  logic              mod_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] mod_q,
  output logic              irq
);
  localparam int unsigned PMAX = max_of4(PERIOD0, PERIOD1, PERIOD2, PERIOD3);
  localparam int PW = (PMAX > 1) ? $clog2(PMAX) : 1;
  localparam int unsigned PERIODS [NUM_RATES] = '{PERIOD0, PERIOD1, PERIOD2, PERIOD3};

  logic [PW-1:0] lim_tab [NUM_RATES];
  logic [PW-1:0] lim;
  logic [PW-1:0] pre_q;
  logic          step;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
    assign lim_tab[g] = PW'(PERIODS[g] - 1);
  end

  assign lim  = lim_tab[rate];
  assign step = tick && en && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (tick && en) begin
      pre_q <= step ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cnt_wr) begin
        cnt_q <= wdata;
      end else if (step) begin
        if (&cnt_q) begin
          cnt_q <= mod_q;
          irq   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         mod_q <= '0;
    else if (mod_wr) mod_q <= wdata;
  end
endmodule

// File: rtl/timer_periph.sv
module timer_periph
  import timer_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hFF04,
  parameter int DIV_PERIOD = 256,
  parameter int PERIOD0    = 1024,
  parameter int PERIOD1    = 16,
  parameter int PERIOD2    = 64,
  parameter int PERIOD3    = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  logic [DATA_W-1:0] div_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] mod_q;
  ctl_t              ctl_q;
  logic              en_q;
  logic [RATE_W-1:0] rate_q;
  logic              div_clr;
  logic              cnt_wr;
  logic              mod_wr;
  logic              ctl_wr;
  logic              restart;

  assign en_q   = ctl_q.en;
  assign rate_q = ctl_q.rate;

  timer_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .div_val(div_q), .cnt_val(cnt_q), .mod_val(mod_q), .ctl_val(ctl_q),
    .div_clr(div_clr), .cnt_wr(cnt_wr), .mod_wr(mod_wr), .ctl_wr(ctl_wr),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  timer_divider #(
    .DATA_W(DATA_W), .DIV_PERIOD(DIV_PERIOD)
  ) u_div (
    .clk(clk), .rst(rst), .tick(tick), .clr(div_clr), .div_q(div_q)
  );

  timer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr(ctl_wr),
    .wr_en_bit(bus_wdata[CTL_EN_BIT]), .wr_rate(bus_wdata[RATE_W-1:0]),
    .ctl_q(ctl_q), .restart(restart)
  );

  timer_counter #(
    .DATA_W(DATA_W), .PERIOD0(PERIOD0), .PERIOD1(PERIOD1),
    .PERIOD2(PERIOD2), .PERIOD3(PERIOD3)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .en(en_q), .rate(rate_q),
    .restart(restart), .cnt_wr(cnt_wr), .mod_wr(mod_wr), .wdata(bus_wdata),
    .cnt_q(cnt_q), .mod_q(mod_q), .irq(irq)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mod_q,
  input logic [DATA_W-1:0] div_q,
  input logic              en_q,
  input logic [1:0]        rate_q,
  input logic              cnt_wr,
  input logic              div_clr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid
);
  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_reload_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt_q == $past(mod_q)));

  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));

  p_div_clear_r3: assert property (@(posedge clk) disable iff (rst)
    div_clr |=> (div_q == '0));

  p_rate_kept_r7: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(rate_q));

  p_wr_wins_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> !irq);

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> (bus_rdata == '0));
endmodule

bind timer_periph timer_checker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .irq(irq), .cnt_q(cnt_q), .mod_q(mod_q), .div_q(div_q),
  .en_q(en_q), .rate_q(rate_q), .cnt_wr(cnt_wr), .div_clr(div_clr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
);

// File: tb/test_timer_periph.sv
module test_timer_periph;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'hFF04;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int irq_total = 0;
  int irq_last = -1;
  int irq_double = 0;
  logic irq_prev = 1'b0;

  timer_periph i_timer_periph (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // irq seen at edge X+1 was set at edge X; cyc still reads X here
  always @(posedge clk) begin
    if (!rst && irq) begin
      irq_total = irq_total + 1;
      irq_last  = cyc;
      if (irq_prev) irq_double = irq_double + 1;
    end
    irq_prev = irq;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, output int e);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    e = cyc; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output int d, output int v, output int e);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    e = cyc; d = int'(bus_rdata); v = int'(bus_rvalid); bus_rd = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic int div_exp(input int er, input int ec);
    return ((er - 1 - ec) / 256) % 256;
  endfunction

  function automatic int cnt_after(input int start, input int m, input int n,
                                   output int ovf);
    int v;
    v = start; ovf = 0;
    for (int i = 0; i < n; i++) begin
      if (v == 255) begin v = m; ovf++; end
      else v = v + 1;
    end
    return v;
  endfunction

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int d, v, e, ec, ee, ed, base, ovf, expv, d1, d2, d3, d4;
    repeat (4) @(negedge clk);
    ec = cyc;
    rst = 1'b0;

    // R1 reset state
    rd(BASE + 16'd0, d, v, e); chk("R1 divider", d, 0); chk("R9 valid flag", v, 1);
    rd(BASE + 16'd1, d, v, e); chk("R1 counter", d, 0);
    rd(BASE + 16'd2, d, v, e); chk("R1 modulo", d, 0);
    rd(BASE + 16'd3, d, v, e); chk("R1 control", d, 0);
    chk("R1 irq low", int'(irq), 0);

    // R2 divider boundaries after reset
    wait_until(ec + 255);
    rd(BASE, d, v, e); chk("R2 div before step", d, div_exp(e, ec));
    rd(BASE, d, v, e); chk("R2 div after step", d, div_exp(e, ec));
    wait_until(ec + 700);
    rd(BASE, d, v, e); chk("R2 div later", d, div_exp(e, ec));

    // R3 divider clear by any data
    wr(BASE, 8'hA5, ec);
    rd(BASE, d, v, e); chk("R3 div cleared", d, 0);
    wait_until(ec + 255);
    rd(BASE, d, v, e); chk("R3 div 255 ticks", d, 0);
    rd(BASE, d, v, e); chk("R3 div 256 ticks", d, 1);

    // R8 counter and modulo load
    wr(BASE + 16'd1, 8'h5A, e); rd(BASE + 16'd1, d, v, e); chk("R8 counter load", d, 8'h5A);
    wr(BASE + 16'd2, 8'hC3, e); rd(BASE + 16'd2, d, v, e); chk("R8 modulo load", d, 8'hC3);

    // R7/R8 control latching and read-back
    wr(BASE + 16'd3, 8'hFD, e); rd(BASE + 16'd3, d, v, e); chk("R8 ctl enable rate01", d, 8'h05);
    wr(BASE + 16'd3, 8'h00, e); rd(BASE + 16'd3, d, v, e); chk("R7 disable keeps rate", d, 8'h01);
    wr(BASE + 16'd3, 8'h07, e); rd(BASE + 16'd3, d, v, e); chk("R7 enable latches rate11", d, 8'h07);
    wr(BASE + 16'd3, 8'h04, e); rd(BASE + 16'd3, d, v, e); chk("R7 enabled write keeps rate", d, 8'h07);
    wr(BASE + 16'd3, 8'h00, e); rd(BASE + 16'd3, d, v, e); chk("R7 disabled rate11", d, 8'h03);

    // R7 rate kept in effect while enabled
    wr(BASE + 16'd1, 8'h00, e);
    wr(BASE + 16'd3, 8'h05, ee);
    wr(BASE + 16'd3, 8'h07, e);
    wait_until(ee + 160);
    rd(BASE + 16'd1, d, v, e); chk("R7 period stays 16", d, (e - 1 - ee) / 16);

    // R6 disabled hold, divider runs
    wr(BASE + 16'd3, 8'h00, ed);
    rd(BASE + 16'd1, d1, v, e);
    wait_until(ed + 500);
    rd(BASE + 16'd1, d2, v, e); chk("R6 counter holds", d2, d1);
    rd(BASE, d, v, e); chk("R6 divider runs", d, div_exp(e, ec));

    // R4/R5 sweep over all rates
    for (int s = 0; s < 4; s++) begin
      int p, m;
      p = (s == 0) ? 1024 : (s == 1) ? 16 : (s == 2) ? 64 : 256;
      m = (s == 3) ? 8'hFF : (8'h20 + s);
      wr(BASE + 16'd3, 8'h00, e);
      wr(BASE + 16'd1, 8'hFD, e);
      wr(BASE + 16'd2, m[7:0], e);
      base = irq_total;
      wr(BASE + 16'd3, 8'h04 | s[7:0], ee);
      wait_until(ee + 3*p - 1);
      rd(BASE + 16'd1, d, v, e);
      expv = cnt_after(8'hFD, m, (e - 1 - ee) / p, ovf);
      chk($sformatf("R4 rate%0d before overflow", s), d, expv);
      chk($sformatf("R5 rate%0d no irq yet", s), irq_total - base, ovf);
      rd(BASE + 16'd1, d, v, e);
      expv = cnt_after(8'hFD, m, (e - 1 - ee) / p, ovf);
      chk($sformatf("R5 rate%0d reload value", s), d, expv);
      chk($sformatf("R5 rate%0d irq count", s), irq_total - base, ovf);
      chk($sformatf("R5 rate%0d irq edge", s), irq_last, ee + 3*p);
      wait_until(ee + 5*p);
      rd(BASE + 16'd1, d, v, e);
      expv = cnt_after(8'hFD, m, (e - 1 - ee) / p, ovf);
      chk($sformatf("R4 rate%0d after 5 periods", s), d, expv);
      chk($sformatf("R5 rate%0d irq total", s), irq_total - base, ovf);
    end

    // R10 counter write collides with overflow
    wr(BASE + 16'd3, 8'h00, e);
    wr(BASE + 16'd1, 8'hFF, e);
    wr(BASE + 16'd2, 8'h40, e);
    base = irq_total;
    wr(BASE + 16'd3, 8'h05, ee);
    wait_until(ee + 15);
    wr(BASE + 16'd1, 8'h11, e); chk("R10 write edge", e, ee + 16);
    rd(BASE + 16'd1, d, v, e); chk("R10 write wins", d, 8'h11);
    chk("R10 no irq", irq_total - base, 0);
    wait_until(ee + 32);
    rd(BASE + 16'd1, d, v, e); chk("R10 counting resumes", d, 8'h12);

    // R11 tick low freezes everything
    tick = 1'b0;
    rd(BASE, d1, v, e); rd(BASE + 16'd1, d3, v, e);
    repeat (400) @(negedge clk);
    rd(BASE, d2, v, e); rd(BASE + 16'd1, d4, v, e);
    chk("R11 divider frozen", d2, d1);
    chk("R11 counter frozen", d4, d3);
    tick = 1'b1;

    // R9 out-of-range reads
    rd(16'hFF08, d, v, e); chk("R9 above data", d, 0); chk("R9 above valid", v, 0);
    rd(16'hFF03, d, v, e); chk("R9 below data", d, 0); chk("R9 below valid", v, 0);
    rd(16'h0005, d, v, e); chk("R9 far data", d, 0); chk("R9 far valid", v, 0);

    // R2 full divider wrap with no interrupt
    wr(BASE + 16'd3, 8'h00, e);
    base = irq_total;
    wr(BASE, 8'h00, ec);
    wait_until(ec + 65535);
    rd(BASE, d, v, e); chk("R2 div at 0xFF", d, div_exp(e, ec));
    rd(BASE, d, v, e); chk("R2 div wrapped", d, div_exp(e, ec));
    chk("R2 wrap no irq", irq_total - base, 0);

    chk("R5 irq single cycle", irq_double, 0);
    summary();
    $finish;
  end
endmodule